// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Controller

This block pairs two eight-line priority interrupt controllers in a cascade and handles the acknowledge side of both. Sixteen request lines come in. Lines 0 to 7 belong to the primary controller and lines 8 to 15 to the secondary. The secondary's interrupt output is wired internally as a level request on primary line 2. The block raises a single CPU interrupt line. When the CPU pulses the acknowledge strobe, the block returns an 8-bit vector and the 4-bit number of the line it granted.

Each controller has the following state:
- a request register, fed by the edges seen on its lines;
- an in-service register;
- a rotation base, which sets the lowest-numbered line of highest priority;
- a trigger-mode register, which selects edge or level behaviour per line at acknowledge time.

Line masks, vector bases and the end-of-interrupt modes are static inputs supplied by the surrounding command logic. A specific end-of-interrupt strobe clears one in-service bit.

Top module: `cascade_intc`

## Requirements
- R1: After reset, `int_o` and `ack_vld_o` are 0, both trigger read-backs are 0, no line is in service, and both rotation bases are 0.
- R2: A rising edge on any line except line 2 sets that line's request bit, and a falling edge clears it. A line whose mask bit is 1 never raises `int_o`.
- R3: Edges on external line 2 have no effect. Primary line 2 instead follows the secondary's internal interrupt output as a level.
- R4: A controller interrupts when the best unmasked pending line has strictly higher priority than the best in-service line. Priority runs from the rotation base upward, wrapping modulo 8. With base 0, line 0 is highest.
- R5: On acknowledge, the granted line's request bit is cleared if its trigger bit is 0 (edge) and kept if its trigger bit is 1 (level).
- R6: With `auto_eoi_i`=0, acknowledge sets the granted line's in-service bit. With `auto_eoi_i`=1 no bit is set. If `rot_aeoi_i`=1 as well, that controller's rotation base becomes (granted line + 1) mod 8.
- R7: When the primary grants line 2, it sets its own in-service bit 2. The secondary then grants its own winner, and the reported line is that winner plus 8.
- R8: The cycle after a granted acknowledge, `ack_vld_o` is 1. `ack_vec_o` is then the owning controller's base with bits 2:0 cleared, plus the granted line mod 8.
- R9: An acknowledge while `int_o` is 0 gives `ack_vld_o`=0 in the next cycle and changes no in-service bit or rotation base.
- R10: A trigger write (`trig_sel_i`=0 primary, 1 secondary) keeps bits 0xF8 on the primary and 0xDE on the secondary. Primary bit 2 is always stored as level but reads back as 0.
- R11: An end-of-interrupt pulse clears the in-service bit of line `eoi_irq_i`: the primary for values 0 to 7, the secondary for values 8 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Request lines; 0-7 primary, 8-15 secondary |
| m_mask_i | input | 8 | Primary line masks (1 = masked) |
| s_mask_i | input | 8 | Secondary line masks (1 = masked) |
| m_base_i | input | 8 | Primary vector base |
| s_base_i | input | 8 | Secondary vector base |
| auto_eoi_i | input | 1 | Automatic end of interrupt for both controllers |
| rot_aeoi_i | input | 1 | Rotate the priority base on automatic end of interrupt |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| eoi_i | input | 1 | Specific end-of-interrupt strobe |
| eoi_irq_i | input | 4 | Line whose in-service bit is cleared |
| trig_we_i | input | 1 | Trigger-mode register write |
| trig_sel_i | input | 1 | Trigger register select: 0 primary, 1 secondary |
| trig_wdata_i | input | 8 | Trigger write data (1 = level) |
| int_o | output | 1 | CPU interrupt line |
| ack_vld_o | output | 1 | Acknowledge granted, one cycle after `ack_i` |
| ack_vec_o | output | 8 | Vector of the last grant |
| ack_irq_o | output | 4 | Line number of the last grant |
| m_trig_o | output | 8 | Primary trigger read-back |
| s_trig_o | output | 8 | Secondary trigger read-back |

## Verification
The assertions assume that `ack_i` and `eoi_i` are single-cycle strobes that never fall in the same cycle. They also assume that the configuration inputs do not change in the cycle an acknowledge is issued. The stimulus keeps to this by driving each pulse for exactly one clock through its own task, with idle cycles between operations. Each configuration change is made in a cycle of its own, away from any acknowledge. Request edges are also kept out of acknowledge cycles. A behavioural model in the bench still applies edges before the acknowledge clear, matching the documented ordering.

// File: rtl/cascade_intc.sv
module cascade_intc #(
  parameter int CASCADE_LINE = 2,
  parameter logic [7:0] M_TRIG_KEEP = 8'hF8,
  parameter logic [7:0] S_TRIG_KEEP = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] req_i,
  input  logic [7:0]  m_mask_i,
  input  logic [7:0]  s_mask_i,
  input  logic [7:0]  m_base_i,
  input  logic [7:0]  s_base_i,
  input  logic        auto_eoi_i,
  input  logic        rot_aeoi_i,
  input  logic        ack_i,
  input  logic        eoi_i,
  input  logic [3:0]  eoi_irq_i,
  input  logic        trig_we_i,
  input  logic        trig_sel_i,
  input  logic [7:0]  trig_wdata_i,
  output logic        int_o,
  output logic        ack_vld_o,
  output logic [7:0]  ack_vec_o,
  output logic [3:0]  ack_irq_o,
  output logic [7:0]  m_trig_o,
  output logic [7:0]  s_trig_o
);
  localparam logic [7:0]  CAS_BIT = 8'(1) << CASCADE_LINE;
  localparam logic [15:0] EXT_IGNORE = 16'(CAS_BIT);

  function automatic logic [3:0] rank(input logic [7:0] v, input logic [2:0] base);
    rank = 4'd8;
    for (int i = 7; i >= 0; i--)
      if (v[base + 3'(i)]) rank = 4'(i);
  endfunction

  logic [1:0][7:0] irr, isr, trg, pend, hit;
  logic [1:0][2:0] rot, win;
  logic [1:0][3:0] p_rank, s_rank;
  logic [1:0]      int_c;
  logic [15:0]     req_q, rise, fall, eoi_m;
  logic            m_go, s_go;

  assign pend[1] = irr[1] & ~s_mask_i;
  assign pend[0] = ((irr[0] & ~CAS_BIT) | (int_c[1] ? CAS_BIT : 8'h00)) & ~m_mask_i;

  for (genvar c = 0; c < 2; c++) begin : g_ctl
    assign p_rank[c] = rank(pend[c], rot[c]);
    assign s_rank[c] = rank(isr[c], rot[c]);
    assign int_c[c]  = p_rank[c] < s_rank[c];
    assign win[c]    = p_rank[c][2:0] + rot[c];
  end

  assign int_o = int_c[0];
  assign m_go  = ack_i & int_c[0];
  assign s_go  = m_go & (win[0] == 3'(CASCADE_LINE));
  assign hit[0] = m_go ? (8'(1) << win[0]) : 8'h00;
  assign hit[1] = s_go ? (8'(1) << win[1]) : 8'h00;

  assign rise  = req_i & ~req_q & ~EXT_IGNORE;
  assign fall  = ~req_i & req_q & ~EXT_IGNORE;
  assign eoi_m = eoi_i ? (16'(1) << eoi_irq_i) : 16'h0000;

  assign m_trig_o = trg[0] & M_TRIG_KEEP;
  assign s_trig_o = trg[1] & S_TRIG_KEEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= '0;
      irr       <= '0;
      isr       <= '0;
      rot       <= '0;
      trg[0]    <= CAS_BIT;
      trg[1]    <= '0;
      ack_vld_o <= 1'b0;
      ack_vec_o <= '0;
      ack_irq_o <= '0;
    end else begin
      req_q <= req_i;
      for (int c = 0; c < 2; c++) begin
        irr[c] <= ((irr[c] | rise[c*8 +: 8]) & ~fall[c*8 +: 8]) & ~(hit[c] & ~trg[c]);
        isr[c] <= (isr[c] & ~eoi_m[c*8 +: 8]) | (auto_eoi_i ? 8'h00 : hit[c]);
        if (auto_eoi_i && rot_aeoi_i && (hit[c] != 8'h00))
          rot[c] <= win[c] + 3'd1;
      end
      if (trig_we_i) begin
        if (trig_sel_i) trg[1] <= trig_wdata_i & S_TRIG_KEEP;
        else            trg[0] <= (trig_wdata_i & M_TRIG_KEEP) | CAS_BIT;
      end
      ack_vld_o <= m_go;
      if (m_go) begin
        ack_vec_o <= s_go ? {s_base_i[7:3], win[1]} : {m_base_i[7:3], win[0]};
        ack_irq_o <= {s_go, s_go ? win[1] : win[0]};
      end
    end
  end

  a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !int_o |=> !ack_vld_o);

  a_r9_idle_state: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !int_o && !eoi_i |=> $stable(isr) && $stable(rot));

  a_r8_vec_low: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o |-> ack_vec_o[2:0] == ack_irq_o[2:0]);

  a_r6_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && int_o && !auto_eoi_i && !eoi_i |=> isr[0] != $past(isr[0]));

  a_r7_cascade_isr: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_o && ack_irq_o[3] && !$past(auto_eoi_i) && !$past(eoi_i) |-> isr[0][CASCADE_LINE]);
endmodule

// File: tb/tb_cascade_intc.sv
`timescale 1ns/1ps
module tb_cascade_intc;
  logic clk = 0, rst_n = 0;
  logic [15:0] req_i = 0;
  logic [7:0] m_mask_i = 0, s_mask_i = 0, m_base_i = 8'h23, s_base_i = 8'h77;
  logic auto_eoi_i = 0, rot_aeoi_i = 0, ack_i = 0, eoi_i = 0;
  logic [3:0] eoi_irq_i = 0;
  logic trig_we_i = 0, trig_sel_i = 0;
  logic [7:0] trig_wdata_i = 0;
  logic int_o, ack_vld_o;
  logic [7:0] ack_vec_o, m_trig_o, s_trig_o;
  logic [3:0] ack_irq_o;

  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  cascade_intc dut (.*);

  bit [7:0] r[2], s[2], t[2];
  int rot[2];
  bit [15:0] prev;
  bit e_vld;
  bit [7:0] e_vec;
  bit [3:0] e_irq;

  function automatic int best(int c, bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[(rot[c] + i) % 8]) return i;
    return 8;
  endfunction

  function automatic bit s_int();
    return best(1, r[1] & ~s_mask_i) < best(1, s[1]);
  endfunction

  function automatic bit [7:0] m_pend();
    bit [7:0] v = r[0];
    v[2] = s_int();
    return v & ~m_mask_i;
  endfunction

  function automatic bit m_int();
    return best(0, m_pend()) < best(0, s[0]);
  endfunction

  task automatic grant(int c, int w);
    if (!t[c][w]) r[c][w] = 0;
    if (!auto_eoi_i) s[c][w] = 1;
    else if (rot_aeoi_i) rot[c] = (w + 1) % 8;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      r = '{0, 0}; s = '{0, 0}; t = '{8'h04, 0}; rot = '{0, 0};
      prev = 0; e_vld = 0; e_vec = 0; e_irq = 0;
    end else begin
      bit go;
      int mw, sw;
      go = ack_i && m_int();
      mw = (best(0, m_pend()) + rot[0]) % 8;
      sw = (best(1, r[1] & ~s_mask_i) + rot[1]) % 8;
      for (int n = 0; n < 16; n++) begin
        if (n == 2) continue;
        if (req_i[n] && !prev[n]) r[n / 8][n % 8] = 1;
        if (!req_i[n] && prev[n]) r[n / 8][n % 8] = 0;
      end
      prev = req_i;
      if (eoi_i) s[eoi_irq_i / 8][eoi_irq_i % 8] = 0;
      e_vld = go;
      if (go) begin
        grant(0, mw);
        if (mw == 2) begin
          grant(1, sw);
          e_vec = (s_base_i & 8'hF8) + 8'(sw);
          e_irq = 4'(sw + 8);
        end else begin
          e_vec = (m_base_i & 8'hF8) + 8'(mw);
          e_irq = 4'(mw);
        end
      end
      if (trig_we_i) begin
        if (trig_sel_i) t[1] = trig_wdata_i & 8'hDE;
        else t[0] = (trig_wdata_i & 8'hF8) | 8'h04;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R4 int_o model", int_o, m_int());
    chk("R8 ack_vld_o model", ack_vld_o, e_vld);
    chk("R8 ack_vec_o model", ack_vec_o, e_vec);
    chk("R7 ack_irq_o model", ack_irq_o, e_irq);
    chk("R10 m_trig_o model", m_trig_o, t[0] & 8'hF8);
    chk("R10 s_trig_o model", s_trig_o, t[1] & 8'hDE);
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic look(); @(negedge clk); endtask
  task automatic setreq(int n, bit v); step(); req_i[n] = v; step(); look(); endtask
  task automatic ack_once(); step(); ack_i = 1; step(); ack_i = 0; look(); endtask
  task automatic eoi_once(int n); step(); eoi_i = 1; eoi_irq_i = 4'(n); step(); eoi_i = 0; look(); endtask
  task automatic trig_wr(bit sel, bit [7:0] d);
    step(); trig_we_i = 1; trig_sel_i = sel; trig_wdata_i = d; step(); trig_we_i = 0; look();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) step();
    rst_n = 1;
    look();
    chk("R1 int_o", int_o, 0);
    chk("R1 ack_vld_o", ack_vld_o, 0);
    chk("R1 m_trig_o", m_trig_o, 0);
    chk("R1 s_trig_o", s_trig_o, 0);

    setreq(5, 1);            chk("R2 rise raises int", int_o, 1);
    ack_once();              chk("R8 vector", ack_vec_o, 8'h25);
    chk("R8 valid", ack_vld_o, 1);
    chk("R5 edge line forgotten", int_o, 0);
    eoi_once(5);             chk("R11 eoi edge", int_o, 0);
    setreq(5, 0);

    setreq(6, 1);
    ack_once();              chk("R8 vector 6", ack_vec_o, 8'h26);
    setreq(7, 1);            chk("R4 lower blocked", int_o, 0);
    setreq(3, 1);            chk("R4 higher nests", int_o, 1);
    ack_once();              chk("R4 nested vector", ack_vec_o, 8'h23);
    eoi_once(3);             chk("R4 still blocked by 6", int_o, 0);
    eoi_once(6);             chk("R11 eoi frees 7", int_o, 1);
    ack_once();              chk("R8 vector 7", ack_vec_o, 8'h27);
    eoi_once(7);
    setreq(3, 0); setreq(6, 0); setreq(7, 0);

    setreq(2, 1);            chk("R3 line 2 ignored", int_o, 0);
    setreq(2, 0);            chk("R3 line 2 fall ignored", int_o, 0);

    setreq(9, 1);            chk("R3 slave drives line 2", int_o, 1);
    ack_once();              chk("R7 slave vector", ack_vec_o, 8'h71);
    chk("R7 irq plus 8", ack_irq_o, 9);
    setreq(8, 1);            chk("R7 master isr2 blocks", int_o, 0);
    eoi_once(2);             chk("R7 master freed", int_o, 1);
    ack_once();              chk("R7 slave line 0", ack_irq_o, 8);
    eoi_once(8); eoi_once(9); eoi_once(2);
    setreq(8, 0); setreq(9, 0);

    trig_wr(0, 8'hFF);       chk("R10 master mask", m_trig_o, 8'hF8);
    trig_wr(1, 8'hFF);       chk("R10 slave mask", s_trig_o, 8'hDE);
    trig_wr(0, 8'h10);       chk("R10 master readback", m_trig_o, 8'h10);
    setreq(4, 1);
    ack_once();              chk("R8 vector 4", ack_vec_o, 8'h24);
    chk("R6 in service blocks", int_o, 0);
    eoi_once(4);             chk("R5 level line kept", int_o, 1);
    setreq(4, 0);            chk("R2 fall clears", int_o, 0);

    step(); m_mask_i = 8'h02;
    setreq(1, 1);            chk("R2 masked line", int_o, 0);
    step(); m_mask_i = 8'h00; look();
    chk("R2 unmasked line", int_o, 1);
    ack_once();              chk("R8 vector 1", ack_vec_o, 8'h21);
    eoi_once(1);
    setreq(1, 0);

    step(); auto_eoi_i = 1; rot_aeoi_i = 1;
    setreq(1, 1);
    ack_once();              chk("R6 auto eoi vector", ack_vec_o, 8'h21);
    chk("R6 auto eoi no isr", int_o, 0);
    step(); req_i[0] = 1; req_i[3] = 1; step(); look();
    ack_once();              chk("R6 rotated winner", ack_vec_o, 8'h23);
    ack_once();              chk("R6 wrap winner", ack_vec_o, 8'h20);
    step(); req_i = 0; step(); look();

    chk("R9 idle int", int_o, 0);
    ack_once();              chk("R9 idle ack invalid", ack_vld_o, 0);
    chk("R9 vector held", ack_vec_o, 8'h20);

    repeat (3) step();
    summary();
    $finish;
  end
endmodule